// File: doc/BRIEF.md
# Keypad-Set Four-Digit Alarm Clock

This block is the core of an hours:minutes alarm clock. A ten-line one-hot digit keypad feeds a four-digit entry buffer. After typing, the user decides what the digits mean by pressing one of two buttons. The time button copies the buffer into the time-of-day counter. The alarm button copies it into the alarm register. If neither button arrives within a timeout, the typed digits are simply abandoned.

A single press of the alarm button, with no digits typed beforehand, previews the stored alarm time for a fixed interval. Otherwise the display shows the running time. The running time advances on an external minute tick.

The block presents the selected four BCD digits and a seven-segment pattern for each digit. It raises an alarm flag whenever the running time equals the alarm time. Tone generation, keypad scanning, debouncing, display multiplexing and the minute prescaler all sit outside the block.

Top module: `alarm_clock_core`

## Requirements
- R1: A key press is any nonzero `key_lines` value. When exactly one line n is high, the decoded digit is n. Any other nonzero pattern enters digit 0.
- R2: Each key press shifts its digit into the lowest entry digit `[3:0]`. The other digits move up by four bits and the top digit is lost. This happens in every controller state.
- R3: From idle, a key press (which wins over the alarm button) moves to key entry. While in key entry, the display shows the entry buffer.
- R4: In key entry with no key pressed, the alarm button moves to set-alarm. Each cycle in set-alarm copies the entry buffer into the alarm register.
- R5: In key entry with neither a key nor the alarm button, the time button moves to set-time. Each cycle in set-time copies the entry buffer into the running time.
- R6: After KEY_TIMEOUT consecutive clocks in key entry without a key or a button, the block returns to idle. Neither the time nor the alarm register is changed.
- R7: From idle, the alarm button alone moves to show-alarm, where the display shows the alarm register. The block returns to idle after SHOW_TIMEOUT consecutive clocks with the button released.
- R8: Set-alarm and set-time persist while their own button is held, even if keys are pressed. They return to idle on release.
- R9: The displayed digits come from the first source that applies: the entry buffer in key entry, the alarm register in show-alarm, and otherwise the running time.
- R10: When `minute_tick` is high, the running time advances by one minute. Minute units count 0–9, minute tens 0–5 and hours 00–23, and 23:59 wraps to 00:00.
- R11: A load into the running time wins over a minute tick in the same cycle.
- R12: `alarm_on` is high exactly when all four running-time digits equal the alarm register.
- R13: Reset clears the entry buffer, alarm register, running time, timeout counter and controller state. Out of reset, the display therefore reads 00:00 and `alarm_on` is high.
- R14: Each seven-segment pattern is {g,f,e,d,c,b,a}, active high: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. Digit i uses `disp_segs[7i+6:7i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_lines | input | 10 | One-hot digit keypad, line n means digit n |
| time_btn | input | 1 | Commit typed digits as the running time |
| alarm_btn | input | 1 | Commit typed digits as alarm, or preview the alarm |
| minute_tick | input | 1 | One-cycle pulse per minute |
| disp_digits | output | 16 | Selected BCD digits, hours tens in [15:12] |
| disp_segs | output | 28 | Seven-segment pattern per digit |
| alarm_on | output | 1 | Running time equals alarm time |

## Verification
Several properties are checked on every cycle:
- a key press from idle always lands in key entry;
- the two load strobes are never high together;
- each key press shifts the entry buffer by one digit;
- a load places exactly the buffer value into its register;
- 23:59 wraps to 00:00 on a tick;
- the timeout counter stays in range.

Other behaviours are shown only by the bench scenarios, which compare against a behavioural model on every clock. These are the length of both timeouts, the preview of the alarm, the abandoning of unconfirmed digits, the load-over-tick priority, and keys typed while a set state is held.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int NDIG = 4;
  localparam int NKEY = 10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ENTRY = 3'd1,
    ST_SETA  = 3'd2,
    ST_SETT  = 3'd3,
    ST_SHOW  = 3'd4
  } ctl_state_e;

  // {g,f,e,d,c,b,a}, active high; non-decimal codes blank
  function automatic logic [6:0] bcd_to_seg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/entry_shifter.sv
module entry_shifter
  import aclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NKEY-1:0]     key_lines,
  output logic                key_valid,
  output logic [NDIG*4-1:0]   entry_q
);
  logic [3:0]        key_digit;
  logic [NDIG*4-1:0] entry_d;

  assign key_valid = |key_lines;

  always_comb begin
    key_digit = 4'd0;
    if ($countones(key_lines) == 1) begin
      for (int n = 0; n < NKEY; n++) begin
        if (key_lines[n]) key_digit = 4'(n);
      end
    end
  end

  always_comb begin
    entry_d = entry_q;
    if (key_valid) entry_d = {entry_q[NDIG*4-5:0], key_digit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_q <= '0;
    else        entry_q <= entry_d;
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> entry_q[NDIG*4-1:4] == $past(entry_q[NDIG*4-5:0]));
endmodule

// File: rtl/time_counter.sv
module time_counter
  import aclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NDIG*4-1:0]   load_val,
  input  logic                tick,
  output logic [NDIG*4-1:0]   cur_q
);
  logic [3:0] mu, mt, hu, ht;
  logic [NDIG*4-1:0] adv, cur_d;

  always_comb begin
    mu = cur_q[3:0];
    mt = cur_q[7:4];
    hu = cur_q[11:8];
    ht = cur_q[15:12];
    if (mu < 4'd9) begin
      mu = mu + 4'd1;
    end else begin
      mu = 4'd0;
      if (mt < 4'd5) begin
        mt = mt + 4'd1;
      end else begin
        mt = 4'd0;
        if (ht >= 4'd2 && hu >= 4'd3) begin
          hu = 4'd0;
          ht = 4'd0;
        end else if (hu >= 4'd9) begin
          hu = 4'd0;
          ht = ht + 4'd1;
        end else begin
          hu = hu + 4'd1;
        end
      end
    end
    adv = {ht, hu, mt, mu};
  end

  always_comb begin
    cur_d = cur_q;
    if (load)      cur_d = load_val;
    else if (tick) cur_d = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur_q == 16'h2359) |=> cur_q == 16'h0000);
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_q == $past(load_val));
endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
  import aclk_pkg::*;
#(
  parameter int KEY_TIMEOUT  = 900,
  parameter int SHOW_TIMEOUT = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_valid,
  input  logic alarm_btn,
  input  logic time_btn,
  output logic load_alarm,
  output logic load_time,
  output logic show_entry,
  output logic show_alarm
);
  localparam int TMAX = (KEY_TIMEOUT > SHOW_TIMEOUT) ? KEY_TIMEOUT : SHOW_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] KEY_LAST  = TW'(KEY_TIMEOUT - 1);
  localparam logic [TW-1:0] SHOW_LAST = TW'(SHOW_TIMEOUT - 1);

  ctl_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic tmr_clr, tmr_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (key_valid)      st_d = ST_ENTRY;
        else if (alarm_btn) st_d = ST_SHOW;
      end
      ST_ENTRY: begin
        if (key_valid)              st_d = ST_ENTRY;
        else if (alarm_btn)         st_d = ST_SETA;
        else if (time_btn)          st_d = ST_SETT;
        else if (tmr_q == KEY_LAST) st_d = ST_IDLE;
      end
      ST_SETA: if (!alarm_btn) st_d = ST_IDLE;
      ST_SETT: if (!time_btn)  st_d = ST_IDLE;
      ST_SHOW: if (!alarm_btn && tmr_q == SHOW_LAST) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_clr = (st_d != st_q) || (st_q == ST_ENTRY && key_valid) ||
              (st_q == ST_SHOW && alarm_btn);
    tmr_en  = (st_q == ST_ENTRY) || (st_q == ST_SHOW);
    tmr_d   = tmr_q;
    if (tmr_clr)     tmr_d = '0;
    else if (tmr_en) tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign load_alarm = (st_q == ST_SETA);
  assign load_time  = (st_q == ST_SETT);
  assign show_entry = (st_q == ST_ENTRY);
  assign show_alarm = (st_q == ST_SHOW);

  assert_idle_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && key_valid) |=> st_q == ST_ENTRY);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_alarm && load_time));
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(TMAX));
endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core
  import aclk_pkg::*;
#(
  parameter int KEY_TIMEOUT  = 900,
  parameter int SHOW_TIMEOUT = 900,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  key_lines,
  input  logic        time_btn,
  input  logic        alarm_btn,
  input  logic        minute_tick,
  output logic [15:0] disp_digits,
  output logic [27:0] disp_segs,
  output logic        alarm_on
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_i;
  logic key_valid, load_alarm, load_time, show_entry, show_alarm;
  logic [NDIG*4-1:0] entry_q, cur_q, alarm_q, alarm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_pipe[SYNC_STAGES-1];

  entry_shifter u_entry (
    .clk(clk), .rst_n(rst_i), .key_lines(key_lines),
    .key_valid(key_valid), .entry_q(entry_q));

  ctrl_fsm #(.KEY_TIMEOUT(KEY_TIMEOUT), .SHOW_TIMEOUT(SHOW_TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .key_valid(key_valid), .alarm_btn(alarm_btn),
    .time_btn(time_btn), .load_alarm(load_alarm), .load_time(load_time),
    .show_entry(show_entry), .show_alarm(show_alarm));

  time_counter u_time (
    .clk(clk), .rst_n(rst_i), .load(load_time), .load_val(entry_q),
    .tick(minute_tick), .cur_q(cur_q));

  always_comb begin
    alarm_d = alarm_q;
    if (load_alarm) alarm_d = entry_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) alarm_q <= '0;
    else        alarm_q <= alarm_d;
  end

  always_comb begin
    if (show_entry)      disp_digits = entry_q;
    else if (show_alarm) disp_digits = alarm_q;
    else                 disp_digits = cur_q;
  end

  assign alarm_on = (cur_q == alarm_q);

  for (genvar i = 0; i < NDIG; i++) begin : g_seg
    assign disp_segs[7*i +: 7] = bcd_to_seg(disp_digits[4*i +: 4]);
  end

  assert_alarm_load_R4: assert property (@(posedge clk) disable iff (!rst_i)
    load_alarm |=> alarm_q == $past(entry_q));
endmodule

// File: tb/sim_alarm_clock_core.sv
`timescale 1ns/1ps
module sim_alarm_clock_core;
  localparam int KTO = 12;
  localparam int STO = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] key_lines = '0;
  logic time_btn = 1'b0, alarm_btn = 1'b0, minute_tick = 1'b0;
  logic [15:0] disp_digits;
  logic [27:0] disp_segs;
  logic alarm_on;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  alarm_clock_core #(.KEY_TIMEOUT(KTO), .SHOW_TIMEOUT(STO)) u0 (
    .clk(clk), .rst_n(rst_n), .key_lines(key_lines), .time_btn(time_btn),
    .alarm_btn(alarm_btn), .minute_tick(minute_tick),
    .disp_digits(disp_digits), .disp_segs(disp_segs), .alarm_on(alarm_on));

  // ---------------- behavioural reference ----------------
  int m_st, m_q;                 // 0 idle 1 entry 2 seta 3 sett 4 show
  int m_buf[4], m_alm[4], m_cur[4];

  function automatic logic [6:0] seg_of(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [15:0] pack4(int a[4]);
    return {4'(a[3]), 4'(a[2]), 4'(a[1]), 4'(a[0])};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_q = 0;
      for (int i = 0; i < 4; i++) begin m_buf[i] = 0; m_alm[i] = 0; m_cur[i] = 0; end
    end else begin
      int ns, kd, ones;
      bit kv;
      kv = (key_lines != 0);
      ones = 0; kd = 0;
      for (int i = 0; i < 10; i++) if (key_lines[i]) begin ones++; kd = i; end
      if (ones != 1) kd = 0;
      ns = m_st;
      case (m_st)
        0: if (kv) ns = 1; else if (alarm_btn) ns = 4;
        1: if (kv) ns = 1; else if (alarm_btn) ns = 2; else if (time_btn) ns = 3;
           else if (m_q == KTO - 1) ns = 0;
        2: if (!alarm_btn) ns = 0;
        3: if (!time_btn) ns = 0;
        4: if (!alarm_btn && m_q == STO - 1) ns = 0;
        default: ns = 0;
      endcase
      // data registers use the state before the edge
      if (m_st == 2) m_alm = m_buf;
      if (m_st == 3) m_cur = m_buf;
      else if (minute_tick) begin
        int t;
        t = (m_cur[3]*10 + m_cur[2]) * 60 + m_cur[1]*10 + m_cur[0];
        t = (t + 1) % 1440;
        m_cur[3] = t / 600; m_cur[2] = (t / 60) % 10;
        m_cur[1] = (t % 60) / 10; m_cur[0] = t % 10;
      end
      if (kv) begin
        m_buf[3] = m_buf[2]; m_buf[2] = m_buf[1]; m_buf[1] = m_buf[0]; m_buf[0] = kd;
      end
      if (ns != m_st || (m_st == 1 && kv) || (m_st == 4 && alarm_btn)) m_q = 0;
      else if (m_st == 1 || m_st == 4) m_q++;
      m_st = ns;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [15:0] ed;
      logic [27:0] es;
      string tag;
      if (m_st == 1)      begin ed = pack4(m_buf); tag = "R3/R9"; end
      else if (m_st == 4) begin ed = pack4(m_alm); tag = "R7/R9"; end
      else                begin ed = pack4(m_cur); tag = "R10/R9"; end
      for (int i = 0; i < 4; i++) es[7*i +: 7] = seg_of(int'(ed[4*i +: 4]));
      chk(tag, 32'(disp_digits), 32'(ed));
      chk("R14", 32'(disp_segs), 32'(es));
      chk("R12", 32'(alarm_on), 32'(pack4(m_cur) == pack4(m_alm)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(logic [9:0] pat);
    @(negedge clk) key_lines = pat;
    @(negedge clk) key_lines = '0;
  endtask

  task automatic type4(int a, int b, int c, int d);
    press(10'(1) << a); press(10'(1) << b); press(10'(1) << c); press(10'(1) << d);
  endtask

  task automatic tick1();
    @(negedge clk) minute_tick = 1'b1;
    @(negedge clk) minute_tick = 1'b0;
  endtask

  task automatic hold_btn(bit is_alarm, int n);
    @(negedge clk);
    if (is_alarm) alarm_btn = 1'b1; else time_btn = 1'b1;
    cyc(n);
    alarm_btn = 1'b0; time_btn = 1'b0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    cmp_on = 1;
    // R13: reset state
    chk("R13", 32'(disp_digits), 32'h0000);
    chk("R13", 32'(alarm_on), 32'd1);
    chk("R13", 32'(disp_segs), 32'({7'h3F, 7'h3F, 7'h3F, 7'h3F}));

    // R2/R3: type 23:58, shown while in entry
    type4(2, 3, 5, 8);
    chk("R2", 32'(disp_digits), 32'h2358);
    // R5: commit as time
    hold_btn(0, 2); cyc(2);
    chk("R5", 32'(disp_digits), 32'h2358);
    // R10: counting and wrap
    tick1(); chk("R10", 32'(disp_digits), 32'h2359);
    tick1(); chk("R10", 32'(disp_digits), 32'h0000);

    // R4: alarm at 00:01
    type4(0, 0, 0, 1);
    hold_btn(1, 2); cyc(2);
    // R7: preview
    @(negedge clk) alarm_btn = 1'b1;
    @(negedge clk) alarm_btn = 1'b0;
    chk("R7", 32'(disp_digits), 32'h0001);
    cyc(STO + 1);
    chk("R7", 32'(disp_digits), 32'h0000);
    // R12: match
    tick1(); chk("R12", 32'(alarm_on), 32'd1);
    tick1(); chk("R12", 32'(alarm_on), 32'd0);

    // R1/R9: non-one-hot patterns enter 0, entry shown over time
    press(10'(1) << 9); press(10'b0000000011); press(10'(1) << 5); press(10'b1100000000);
    chk("R1", 32'(disp_digits), 32'h9050);
    // R6: timeout abandons the digits
    cyc(KTO + 1);
    chk("R6", 32'(disp_digits), 32'h0002);
    @(negedge clk) alarm_btn = 1'b1;
    @(negedge clk) alarm_btn = 1'b0;
    chk("R6", 32'(disp_digits), 32'h0001);
    cyc(STO + 1);

    // R11: load beats tick
    type4(1, 2, 3, 4);
    @(negedge clk) begin time_btn = 1'b1; minute_tick = 1'b1; end
    cyc(2);
    time_btn = 1'b0; minute_tick = 1'b0;
    cyc(2);
    chk("R11", 32'(disp_digits), 32'h1234);
    chk("R14", 32'(disp_segs), 32'({7'h06, 7'h5B, 7'h4F, 7'h66}));

    // R8: set-alarm persists while held, keys still shift in
    type4(1, 2, 3, 4);
    @(negedge clk) alarm_btn = 1'b1;
    cyc(2);
    key_lines = 10'(1) << 5;
    cyc(1);
    key_lines = '0;
    cyc(3);
    alarm_btn = 1'b0;
    cyc(2);
    @(negedge clk) alarm_btn = 1'b1;
    @(negedge clk) alarm_btn = 1'b0;
    chk("R8", 32'(disp_digits), 32'h2345);
    cyc(STO + 2);
    chk("R8", 32'(disp_digits), 32'h1234);

    cmp_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule